// File: doc/BRIEF.md
# Relative-Branch Sequencer with Interrupt Sampling Points

This block sequences relative branches and a generic multi-cycle instruction for an 8-bit accumulator-style core. It also decides, cycle by cycle, when a pending maskable interrupt request is recognised. The request is not checked at every instruction boundary. It is sampled at a few fixed points inside each instruction, and the most recent sample decides whether the next cycle is an opcode fetch or the first cycle of the interrupt entry sequence.

A branch fetches its opcode, then its signed offset byte. When the condition holds, it spends one cycle adding the offset to the low address byte, and one more cycle correcting the high byte when the target lies in another 256-byte page. The request is sampled at the end of the opcode cycle, and again at the end of the add cycle only when a page correction follows. A taken branch that stays in its page therefore does not see a request that arrives after its first cycle; that request waits until one more instruction has completed. The filler instruction is one byte long, has a length encoded in its opcode, and samples the request at the end of its next-to-last cycle. This lets a bench measure latency against branches.

Interrupt entry takes seven cycles. It pushes the return address and the status byte onto the stack page, tells the surrounding core to set its interrupt mask, and loads the program counter from the two bytes at the top of the address space.

Top module: `brq_seq`

## Requirements
- R1: While reset is held, pc_o and addr_o equal RESET_PC, cycle_o is 0 (opcode fetch), and wr_en_o, irq_taken_o and set_imask_o are low.
- R2: An opcode whose bits [4:0] are 10000 is a branch. Any other opcode is a one-byte filler whose length in cycles is bits [2:0], with values 0 and 1 treated as 2. Its first cycle is the opcode fetch.
- R3: A branch whose condition input is low during its offset-fetch cycle takes 2 cycles, and the next fetch is at the opcode address plus 2.
- R4: A taken branch takes 3 cycles when the target stays in the page of (opcode address + 2). The target is (opcode address + 2) plus the sign-extended offset byte.
- R5: A taken branch whose target is in another page takes 4 cycles. Its last cycle is reported as cycle type 3 (page fixup). Crossings work in both directions.
- R6: A request that is present (irq_n_i low, imask_i low) at the end of any branch's first cycle starts interrupt entry directly after that branch.
- R7: A page-crossing taken branch samples the request again at the end of its third cycle. A request that first appears there still starts entry directly after the branch.
- R8: A request that first appears after the first cycle of a same-page taken branch is recognised only after the following instruction. A branch to itself runs one more iteration. A 7-cycle filler at the target gives 9 cycles from assertion to entry.
- R9: A filler samples the request only at the end of its next-to-last cycle.
- R10: While imask_i is high, no interrupt entry starts.
- R11: Entry lasts 7 cycles, all typed 4, with irq_taken_o high in the first. The block then writes, to stack-page addresses 0x01FD, 0x01FC and 0x01FB, the return high byte, the return low byte, and status_i with bit 4 cleared and bit 5 set. set_imask_o is high in the status-write cycle. The next fetch is at the address held in 0xFFFF:0xFFFE.
- R12: The pushed return address is the address that would have been fetched next had no interrupt been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 1 | Level-sensitive, active-low interrupt request |
| imask_i | input | 1 | Interrupt mask flag from the core status |
| cond_i | input | 1 | Branch condition, sampled in the offset-fetch cycle |
| rdata_i | input | 8 | Read data for the current addr_o |
| status_i | input | 8 | Status byte to push on entry |
| pc_o | output | 16 | Program counter |
| addr_o | output | 16 | Memory address of the current cycle |
| wr_en_o | output | 1 | Write strobe for stack pushes |
| wdata_o | output | 8 | Write data |
| cycle_o | output | 3 | Cycle type: 0 fetch, 1 operand, 2 internal, 3 page fixup, 4 interrupt sequence |
| irq_taken_o | output | 1 | High in the first entry cycle |
| set_imask_o | output | 1 | Tells the core to set its interrupt mask |

## Verification
The bench builds the block with RESET_PC at 0x0480. With that value, the first branch's 8-bit offset can reach both the same page and the next page, and a second branch at 0x0500 with offset 0x80 reaches back across the page boundary downward. The stack page and the reset stack pointer keep their defaults, so the push addresses are fixed values the bench can state. Because the request can be raised on any chosen cycle, every sampling point of the 2-, 3- and 4-cycle branch forms and of every filler length falls within reach. This includes the self-branch loop and the longest deferral.

// File: rtl/brq_pkg.sv
package brq_pkg;

  typedef enum logic [2:0] {
    CT_FETCH = 3'd0,
    CT_OPER  = 3'd1,
    CT_INTL  = 3'd2,
    CT_FIX   = 3'd3,
    CT_ISEQ  = 3'd4
  } cyc_t;

  typedef enum logic [3:0] {
    S_FETCH, S_BROP, S_BRADD, S_BRFIX, S_FILL,
    S_E0, S_E1, S_E2, S_E3, S_E4, S_E5, S_E6
  } st_t;

  function automatic cyc_t cyc_of(st_t s);
    case (s)
      S_FETCH:  return CT_FETCH;
      S_BROP:   return CT_OPER;
      S_BRADD:  return CT_INTL;
      S_FILL:   return CT_INTL;
      S_BRFIX:  return CT_FIX;
      default:  return CT_ISEQ;
    endcase
  endfunction

endpackage

// File: rtl/brq_decode.sv
module brq_decode #(
  parameter int          LEN_W    = 3,
  parameter int          FILL_MIN = 2,
  parameter logic [4:0]  BR_PAT   = 5'b10000
) (
  input  logic [7:0]       opc_i,
  output logic             is_br_o,
  output logic [LEN_W-1:0] fill_len_o
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(FILL_MIN);

  always_comb begin
    is_br_o    = (opc_i[4:0] == BR_PAT);
    fill_len_o = (opc_i[LEN_W-1:0] < MIN_LEN) ? MIN_LEN : opc_i[LEN_W-1:0];
  end
endmodule

// File: rtl/brq_target.sv
module brq_target #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [7:0]    off_i,
  output logic [AW-1:0] tgt_o,
  output logic          cross_o
);
  localparam int EXT_W = AW - 8;

  always_comb begin
    tgt_o   = base_i + {{EXT_W{off_i[7]}}, off_i};
    cross_o = (tgt_o[AW-1:8] != base_i[AW-1:8]);
  end
endmodule

// File: rtl/brq_poll.sv
module brq_poll (
  input  logic clk_i,
  input  logic rst_i,
  input  logic poll_i,
  input  logic clr_i,
  input  logic irq_n_i,
  input  logic imask_i,
  output logic take_o
);
  logic take_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       take_q <= 1'b0;
    else if (clr_i)  take_q <= 1'b0;
    else if (poll_i) take_q <= ~irq_n_i & ~imask_i;
  end

  assign take_o = take_q;

  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
    (poll_i && imask_i && !clr_i) |=> !take_q); // R10

  AST_HOLD_BETWEEN_POLLS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!poll_i && !clr_i) |=> $stable(take_q)); // R9
endmodule

// File: rtl/brq_seq.sv
module brq_seq
  import brq_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              LEN_W      = 3,
  parameter int              FILL_MIN   = 2,
  parameter logic [AW-1:0]   RESET_PC   = 16'h0200,
  parameter logic [AW-9:0]   STACK_PAGE = 8'h01,
  parameter logic [7:0]      SP_INIT    = 8'hFD
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          irq_n_i,
  input  logic          imask_i,
  input  logic          cond_i,
  input  logic [7:0]    rdata_i,
  input  logic [7:0]    status_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic [7:0]    wdata_o,
  output logic [2:0]    cycle_o,
  output logic          irq_taken_o,
  output logic          set_imask_o
);
  localparam logic [AW-1:0]    VEC_HI = {AW{1'b1}};
  localparam logic [AW-1:0]    VEC_LO = VEC_HI - AW'(1);
  localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO    = LEN_W'(2);

  st_t             st_q, st_n;
  logic [AW-1:0]   pc_q, pc_n, addr_q, addr_n, tgt_q, tgt_n, fin_pc;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [7:0]      sp_q, sp_n, wd_q, wd_n;
  logic            cross_q, cross_n, wr_q, wr_n, tk_q, tk_n, si_q, si_n;
  cyc_t            cyc_q;
  logic            fin, poll, clr, take;

  logic             is_br;
  logic [LEN_W-1:0] fill_len;
  logic [AW-1:0]    pc_inc, br_tgt;
  logic             br_cross;

  assign pc_inc = pc_q + AW'(1);

  brq_decode #(.LEN_W(LEN_W), .FILL_MIN(FILL_MIN)) u_dec (
    .opc_i      (rdata_i),
    .is_br_o    (is_br),
    .fill_len_o (fill_len)
  );

  brq_target #(.AW(AW)) u_tgt (
    .base_i  (pc_inc),
    .off_i   (rdata_i),
    .tgt_o   (br_tgt),
    .cross_o (br_cross)
  );

  brq_poll u_poll (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .poll_i  (poll),
    .clr_i   (clr),
    .irq_n_i (irq_n_i),
    .imask_i (imask_i),
    .take_o  (take)
  );

  always_comb begin
    st_n    = st_q;
    pc_n    = pc_q;
    addr_n  = addr_q;
    tgt_n   = tgt_q;
    cross_n = cross_q;
    rem_n   = rem_q;
    sp_n    = sp_q;
    wr_n    = 1'b0;
    wd_n    = wd_q;
    si_n    = 1'b0;
    poll    = 1'b0;
    fin     = 1'b0;
    fin_pc  = pc_q;
    case (st_q)
      S_FETCH: begin
        pc_n   = pc_inc;
        addr_n = pc_inc;
        poll   = 1'b1;
        if (is_br) begin
          st_n = S_BROP;
        end else begin
          st_n  = S_FILL;
          rem_n = fill_len - ONE;
          poll  = (fill_len == TWO);
        end
      end
      S_FILL: begin
        if (rem_q == ONE) begin
          fin    = 1'b1;
          fin_pc = pc_q;
        end else begin
          rem_n  = rem_q - ONE;
          poll   = (rem_q == TWO);
          addr_n = pc_q;
        end
      end
      S_BROP: begin
        if (!cond_i) begin
          fin    = 1'b1;
          fin_pc = pc_inc;
        end else begin
          st_n    = S_BRADD;
          tgt_n   = br_tgt;
          cross_n = br_cross;
          pc_n    = pc_inc;
          addr_n  = pc_inc;
        end
      end
      S_BRADD: begin
        if (!cross_q) begin
          fin    = 1'b1;
          fin_pc = tgt_q;
        end else begin
          poll   = 1'b1;
          st_n   = S_BRFIX;
          addr_n = {pc_q[AW-1:8], tgt_q[7:0]};
        end
      end
      S_BRFIX: begin
        fin    = 1'b1;
        fin_pc = tgt_q;
      end
      S_E0: begin
        st_n   = S_E1;
        addr_n = pc_q;
      end
      S_E1: begin
        st_n   = S_E2;
        addr_n = {STACK_PAGE, sp_q};
        wr_n   = 1'b1;
        wd_n   = pc_q[AW-1:8];
      end
      S_E2: begin
        sp_n   = sp_q - 8'd1;
        st_n   = S_E3;
        addr_n = {STACK_PAGE, sp_q - 8'd1};
        wr_n   = 1'b1;
        wd_n   = pc_q[7:0];
      end
      S_E3: begin
        sp_n   = sp_q - 8'd1;
        st_n   = S_E4;
        addr_n = {STACK_PAGE, sp_q - 8'd1};
        wr_n   = 1'b1;
        wd_n   = {status_i[7:6], 1'b1, 1'b0, status_i[3:0]};
        si_n   = 1'b1;
      end
      S_E4: begin
        sp_n   = sp_q - 8'd1;
        st_n   = S_E5;
        addr_n = VEC_LO;
      end
      S_E5: begin
        pc_n   = {pc_q[AW-1:8], rdata_i};
        st_n   = S_E6;
        addr_n = VEC_HI;
      end
      S_E6: begin
        fin    = 1'b1;
        fin_pc = {rdata_i, pc_q[7:0]};
      end
      default: begin
        st_n   = S_FETCH;
        addr_n = pc_q;
      end
    endcase
    clr  = 1'b0;
    tk_n = 1'b0;
    if (fin) begin
      pc_n   = fin_pc;
      addr_n = fin_pc;
      if (take) begin
        st_n = S_E0;
        tk_n = 1'b1;
        clr  = 1'b1;
      end else begin
        st_n = S_FETCH;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= S_FETCH;
      pc_q    <= RESET_PC;
      addr_q  <= RESET_PC;
      tgt_q   <= '0;
      cross_q <= 1'b0;
      rem_q   <= '0;
      sp_q    <= SP_INIT;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      tk_q    <= 1'b0;
      si_q    <= 1'b0;
      cyc_q   <= CT_FETCH;
    end else begin
      st_q    <= st_n;
      pc_q    <= pc_n;
      addr_q  <= addr_n;
      tgt_q   <= tgt_n;
      cross_q <= cross_n;
      rem_q   <= rem_n;
      sp_q    <= sp_n;
      wr_q    <= wr_n;
      wd_q    <= wd_n;
      tk_q    <= tk_n;
      si_q    <= si_n;
      cyc_q   <= cyc_of(st_n);
    end
  end

  assign pc_o        = pc_q;
  assign addr_o      = addr_q;
  assign wr_en_o     = wr_q;
  assign wdata_o     = wd_q;
  assign cycle_o     = cyc_q;
  assign irq_taken_o = tk_q;
  assign set_imask_o = si_q;

  AST_NOTTAKEN_TWO: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == S_BROP && !cond_i) |=> (cycle_o == 3'd0 || irq_taken_o)); // R3

  AST_FIX_AFTER_CROSS: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == S_BRADD && cross_q) |=> (cycle_o == 3'd3)); // R5

  AST_SAMEPAGE_DEFER: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == S_BRADD && !cross_q && !take) |=> !irq_taken_o); // R8

  AST_TAKEN_NEEDS_POLL: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_taken_o) |-> $past(take)); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({irq_taken_o, wr_en_o})); // R11

  AST_VECTOR_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == S_E6) |=> (cycle_o == 3'd0 && addr_o == {$past(rdata_i), $past(pc_q[7:0])})); // R11
endmodule

// File: tb/brq_seq_tb_top.sv
`timescale 1ns/1ps
module brq_seq_tb_top;
  localparam logic [15:0] BASE    = 16'h0480;
  localparam logic [15:0] VEC     = 16'h0C00;
  localparam int          HORIZON = 40;
  localparam int          RUNLEN  = 60;
  localparam logic [7:0]  STATUS  = 8'hDB;
  localparam logic [7:0]  PUSHED  = 8'hEB;

  logic clk = 1'b0, rst = 1'b1, irq_n = 1'b1, imask = 1'b0, cond;
  logic [7:0]  rdata, wdata;
  logic [15:0] pc, addr;
  logic        wr_en, taken, seti;
  logic [2:0]  cyc;

  logic [7:0] mem  [0:4095];
  logic       cmap [0:4095];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int          ef_cyc [0:63];
  logic [15:0] ef_adr [0:63];
  int          ef_n, e_cyc;
  logic [15:0] e_ret;

  always #4 clk = ~clk;

  function automatic logic [7:0] rd(logic [15:0] a);
    if (a >= 16'hFFFE) return a[0] ? VEC[15:8] : VEC[7:0];
    return mem[a[11:0]];
  endfunction

  assign rdata = rd(addr);
  assign cond  = cmap[pc[11:0]];

  brq_seq #(.RESET_PC(BASE)) dut_i (
    .clk_i(clk), .rst_i(rst), .irq_n_i(irq_n), .imask_i(imask), .cond_i(cond),
    .rdata_i(rdata), .status_i(STATUS), .pc_o(pc), .addr_o(addr),
    .wr_en_o(wr_en), .wdata_o(wdata), .cycle_o(cyc),
    .irq_taken_o(taken), .set_imask_o(seti)
  );

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference from R2..R9: per instruction length, last sampling cycle, next pc
  task automatic predict(int k, bit msk);
    logic [15:0] p, nx, t, oa, npc;
    logic [7:0]  op, off;
    int c, n, pl, len;
    p = BASE; c = 0; ef_n = 0; e_cyc = -1; e_ret = '0;
    while (c < HORIZON && e_cyc < 0) begin
      op = rd(p);
      ef_cyc[ef_n] = c; ef_adr[ef_n] = p; ef_n++;
      if (op[4:0] == 5'b10000) begin
        oa = p + 16'd1; off = rd(oa); nx = p + 16'd2;
        t  = nx + {{8{off[7]}}, off};
        if (!cmap[oa[11:0]])          begin n = 2; pl = c;     npc = nx; end
        else if (t[15:8] == nx[15:8]) begin n = 3; pl = c;     npc = t;  end
        else                          begin n = 4; pl = c + 2; npc = t;  end
      end else begin
        len = (op[2:0] < 3'd2) ? 2 : int'(op[2:0]);
        n = len; pl = c + len - 2; npc = p + 16'd1;
      end
      if (!msk && pl >= k) begin
        e_cyc = c + n; e_ret = npc;
        ef_cyc[ef_n] = c + n + 7; ef_adr[ef_n] = VEC; ef_n++;
      end
      p = npc; c = c + n;
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 8'($urandom_range(0, 7));
      cmap[i] = 1'b0;
    end
  endtask

  task automatic run_case(int k, bit msk, string tf, string te, output int got_e);
    int idx, np, si_c, lim;
    logic [15:0] pa [0:2];
    logic [7:0]  pd [0:2];
    string tg;
    predict(k, msk);
    lim = (e_cyc >= 0) ? e_cyc + 7 : HORIZON - 1;
    imask = msk; irq_n = 1'b1; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idx = 0; got_e = -1; np = 0; si_c = -1;
    for (int c = 0; c < RUNLEN; c++) begin
      if (cyc == 3'd0 && c <= lim) begin
        if (e_cyc >= 0 && idx == ef_n - 1) tg = "R11";
        else tg = (idx < 2) ? tf : "R2";
        if (idx < ef_n)
          chk(ef_cyc[idx] == c && ef_adr[idx] == addr, tg, "fetch cycle:addr",
              longint'(c) * 65536 + longint'(addr),
              longint'(ef_cyc[idx]) * 65536 + longint'(ef_adr[idx]));
        else
          chk(1'b0, tg, "extra fetch", longint'(addr), 0);
        idx++;
      end
      if (taken && got_e < 0) got_e = c;
      if (wr_en && np < 3) begin pa[np] = addr; pd[np] = wdata; np++; end
      if (seti && si_c < 0) si_c = c;
      irq_n = !(c >= k && got_e < 0);
      @(negedge clk);
    end
    irq_n = 1'b1;
    chk(idx == ef_n, tf, "fetch count", idx, ef_n);
    chk(got_e == e_cyc, te, "entry cycle", got_e, e_cyc);
    if (e_cyc >= 0) begin
      chk(np == 3, "R11", "push count", np, 3);
      chk(pa[0] == 16'h01FD && pa[1] == 16'h01FC && pa[2] == 16'h01FB, "R11", "push addrs",
          {pa[0], pa[1], pa[2]}, 48'h01FD_01FC_01FB);
      chk({pd[0], pd[1]} == e_ret, "R12", "return addr", {pd[0], pd[1]}, e_ret);
      chk(pd[2] == PUSHED, "R11", "pushed status", pd[2], PUSHED);
      chk(si_c == e_cyc + 4, "R11", "mask-set cycle", si_c, e_cyc + 4);
    end
  endtask

  function automatic string kind_tag(logic [7:0] off, bit cnd, bit for_entry);
    logic [15:0] t;
    t = 16'h0482 + {{8{off[7]}}, off};
    if (!cnd) return for_entry ? "R6" : "R3";
    if (t[15:8] == 8'h04) return for_entry ? "R8" : "R4";
    return for_entry ? "R7" : "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ge;
    void'($urandom(32'd1234));
    fill_mem();
    // R1: reset state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == BASE && addr == BASE, "R1", "reset pc/addr", addr, BASE);
    chk(cyc == 3'd0 && !wr_en && !taken && !seti, "R1", "reset strobes",
        {cyc, wr_en, taken, seti}, 0);

    // R3/R6: not taken, request at cycle 0
    fill_mem(); mem[12'h480] = 8'h10; mem[12'h481] = 8'h05;
    run_case(0, 0, "R3", "R6", ge);
    chk(ge == 2, "R6", "not-taken entry", ge, 2);
    // R4/R6: taken same page, request at cycle 0
    cmap[12'h481] = 1'b1;
    run_case(0, 0, "R4", "R6", ge);
    chk(ge == 3, "R6", "same-page entry", ge, 3);
    // R8: deferral with 7-cycle target, 9-cycle latency
    mem[12'h481] = 8'h10; mem[12'h492] = 8'h07;
    run_case(1, 0, "R4", "R8", ge);
    chk(ge - 1 == 9, "R8", "max latency", ge - 1, 9);
    // R5/R7: page cross up, request at third cycle
    fill_mem(); mem[12'h480] = 8'h30; mem[12'h481] = 8'h7E; cmap[12'h481] = 1'b1;
    run_case(2, 0, "R5", "R7", ge);
    chk(ge == 4, "R7", "cross re-sample entry", ge, 4);
    run_case(3, 0, "R5", "R7", ge);
    // R5: chained downward crossing, no request
    mem[12'h500] = 8'h50; mem[12'h501] = 8'h80; cmap[12'h501] = 1'b1;
    run_case(1000, 0, "R5", "R5", ge);
    // R8: branch to itself
    fill_mem(); mem[12'h480] = 8'hF0; mem[12'h481] = 8'hFE; cmap[12'h481] = 1'b1;
    run_case(2, 0, "R8", "R8", ge);
    chk(ge == 6, "R8", "self-loop extra iteration", ge, 6);
    // R9: filler sampling point
    fill_mem(); mem[12'h480] = 8'h05;
    run_case(3, 0, "R9", "R9", ge);
    chk(ge == 5, "R9", "filler last sample", ge, 5);
    run_case(4, 0, "R9", "R9", ge);
    chk(ge != 5, "R9", "filler late request", ge, 6);
    // R2: short opcode value clamps to 2
    mem[12'h480] = 8'h08;
    run_case(0, 0, "R2", "R2", ge);
    chk(ge == 2, "R2", "clamped filler", ge, 2);
    // R10: masked
    run_case(0, 1, "R10", "R10", ge);
    chk(ge == -1, "R10", "masked no entry", ge, -1);

    // random mix
    for (int r = 0; r < 40; r++) begin
      logic [7:0] off;
      bit cnd, msk;
      int k;
      fill_mem();
      off = 8'($urandom_range(0, 255));
      cnd = 1'($urandom_range(0, 1));
      msk = ($urandom_range(0, 7) == 0);
      k   = int'($urandom_range(0, 14));
      mem[12'h480] = {3'($urandom_range(0, 7)), 5'b10000};
      mem[12'h481] = off;
      cmap[12'h481] = cnd;
      run_case(k, msk, kind_tag(off, cnd, 0), msk ? "R10" : kind_tag(off, cnd, 1), ge);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule